// File: doc/BRIEF.md
# Paired-Page Joint Translation Buffer

This block is a fully associative translation buffer that software fills. Each entry holds one virtual tag, which names a pair of adjacent pages. It also holds two physical frame descriptors: one for the even page of the pair and one for the odd page. A per-entry size mask selects page sizes from 4 KB up to 1 MB. Masked tag bits drop out of the compare, and the bit that picks even or odd moves up with the page size. An entry matches when its tag agrees with the lookup address and either its global flag is set or its address-space ID equals the current one. The stored global flag is the AND of two global bits, one written with each half.

Writes arrive through a one-deep staging register. A request is taken when `busy` is low. It lands in the array on the next clock, and `busy` is high for that one cycle, so that a small front-end buffer can stall. The target row is either an explicit index or a replacement pointer. The pointer advances on every clock and cycles through the rows above a programmable count of reserved low rows.

Lookups compare combinationally and register the result. One cycle later the block reports one of two things. On success it gives the physical address, the cacheability code and an uncached flag. Otherwise it gives a fault: miss, invalid half, or store to a clean half.

Top module: `pair_tlb`

## Requirements
- R1: `rst_n` clears the block asynchronously, and the internal reset is released on the second rising clock edge after `rst_n` goes high. After reset `busy` and `rsp_valid` are low, and every lookup misses (fault code 01).
- R2: A write request is taken only when `busy` is low. `busy` is then high for exactly the one following cycle, and a request made while `busy` is high is dropped. A lookup issued once `busy` is low again sees the new entry.
- R3: With `wr_rand`=0 the target row is `wr_index`. With `wr_rand`=1 the target row is the replacement pointer. The pointer resets to 0 and advances every clock. It moves to `rsv_count` when it is at the last row or below `rsv_count`, and otherwise it adds one.
- R4: The stored global flag is `wr_glob0` AND `wr_glob1`. A non-global entry matches only when its stored ID equals `lk_asid`, and a global entry matches any ID.
- R5: The tag holds VA[31:13]. Mask bit j removes VA[13+j] from the compare. The legal masks are 0x00, 0x03, 0x0F, 0x3F and 0xFF, for 4 KB, 16 KB, 64 KB, 256 KB and 1 MB. With n set mask bits, VA[12+n] picks the half: 0 selects the even half (data 0) and 1 selects the odd half (data 1).
- R6: On success, `rsp_pa[11:0]` and the n lowest frame bits `rsp_pa[12+n-1:12]` come from the virtual address. The remaining bits of `rsp_pa[31:12]` come from the selected half's frame number.
- R7: When the selected half's valid bit is clear, any access returns fault 10 (invalid). This fault takes precedence over fault 11.
- R8: A store (`lk_store`=1) to a half whose dirty bit is clear returns fault 11 (modified). A load from that half succeeds.
- R9: On success, `rsp_cca` is the selected half's 3-bit code, and `rsp_uncached` is 1 exactly when that code is 3'b010.
- R10: A response appears on the cycle after `lk_valid`, with `rsp_valid` high for exactly one cycle. The fault codes are 00 for none, 01 for miss, 10 for invalid and 11 for modified, and `rsp_hit` is 1 exactly when the code is 00.
- R11: When several entries match, the lowest-numbered row supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_count | input | 4 | Number of low rows the replacement pointer skips |
| wr_en | input | 1 | Write request |
| wr_rand | input | 1 | 1: write at replacement pointer, 0: at wr_index |
| wr_index | input | 4 | Explicit target row |
| wr_mask | input | 8 | Page size mask |
| wr_vpn2 | input | 19 | Virtual page-pair tag (VA[31:13]) |
| wr_asid | input | 8 | Address-space ID of the entry |
| wr_pfn0 | input | 20 | Even half frame number |
| wr_cca0 | input | 3 | Even half cacheability code |
| wr_dirty0 | input | 1 | Even half write permission |
| wr_valid0 | input | 1 | Even half valid |
| wr_glob0 | input | 1 | Global bit written with the even half |
| wr_pfn1 | input | 20 | Odd half frame number |
| wr_cca1 | input | 3 | Odd half cacheability code |
| wr_dirty1 | input | 1 | Odd half write permission |
| wr_valid1 | input | 1 | Odd half valid |
| wr_glob1 | input | 1 | Global bit written with the odd half |
| busy | output | 1 | Write in progress |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space ID |
| lk_store | input | 1 | Access is a store |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 2 | Fault code |
| rsp_pa | output | 32 | Physical address |
| rsp_cca | output | 3 | Cacheability code |
| rsp_uncached | output | 1 | Page is uncached |

## Verification
The hardest case to reach from the ports is a write in replacement mode. The pointer runs freely every clock, so the row that receives the entry is never visible at the ports. The bench keeps its own copy of the pointer rule, including the two-edge reset release and the reserved-row floor, and notes the predicted row at the moment the request is taken. It then confirms that row by writing a different tag there through an explicit index and checking that the first tag now misses. A write attempted during the busy cycle is also forced on purpose, and a later lookup shows that the dropped entry never arrived. Random traffic mixes every page size, both halves, stores and loads, matching and foreign IDs, and overlapping tags.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 12;
  localparam int PFN_W    = VA_W - PG_SHIFT;
  localparam int VPN2_W   = VA_W - PG_SHIFT - 1;
  localparam int MASK_W   = 8;
  localparam int SPAN_W   = $clog2(MASK_W + 1);
  localparam int POS_W    = $clog2(VA_W);

  localparam logic [2:0] CCA_UNCACHED = 3'b010;

  // one half of a page pair
  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cca;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_MISS     = 2'b01,
    FLT_INVALID  = 2'b10,
    FLT_MODIFIED = 2'b11
  } fault_e;

  // number of set bits in a page mask = extra offset bits beyond 4 KB
  function automatic logic [SPAN_W-1:0] mask_span(input logic [MASK_W-1:0] m);
    logic [SPAN_W-1:0] n;
    n = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (m[i]) n = n + 1'b1;
    end
    return n;
  endfunction

endpackage

// File: rtl/pair_tlb_repl.sv
module pair_tlb_repl #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rsv_count,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] floor_v;
  logic [IDX_W-1:0] ptr_nxt;
  logic             ptr_en;

  always_comb begin
    floor_v = (rsv_count > LAST) ? LAST : rsv_count;
    ptr_en  = 1'b1;
    if ((ptr < floor_v) || (ptr >= LAST)) ptr_nxt = floor_v;
    else                                  ptr_nxt = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_nxt;
  end

endmodule

// File: rtl/pair_tlb_store.sv
module pair_tlb_store
  import pair_tlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int ASID_W  = 8,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_rand,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [IDX_W-1:0]  rep_idx,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  half_t             wr_lo0,
  input  half_t             wr_lo1,
  input  logic              wr_g0,
  input  logic              wr_g1,
  output logic              busy,
  input  logic [VPN2_W-1:0] lk_vpn2,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              sel_hit,
  output logic [MASK_W-1:0] sel_mask,
  output half_t             sel_even,
  output half_t             sel_odd
);

  // ---------------- staging register ----------------
  logic              stg_vld_q, stg_vld_d;
  logic              accept;
  logic [IDX_W-1:0]  stg_idx_q;
  logic [MASK_W-1:0] stg_mask_q;
  logic [VPN2_W-1:0] stg_vpn2_q;
  logic [ASID_W-1:0] stg_asid_q;
  logic              stg_g_q;
  half_t             stg_lo0_q, stg_lo1_q;

  always_comb begin
    accept    = wr_en && !stg_vld_q;
    stg_vld_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_vld_q <= 1'b0;
    else        stg_vld_q <= stg_vld_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      stg_idx_q  <= wr_rand ? rep_idx : wr_index;
      stg_mask_q <= wr_mask;
      stg_vpn2_q <= wr_vpn2;
      stg_asid_q <= wr_asid;
      stg_g_q    <= wr_g0 & wr_g1;
      stg_lo0_q  <= wr_lo0;
      stg_lo1_q  <= wr_lo1;
    end
  end

  assign busy = stg_vld_q;

  // ---------------- entry array ----------------
  logic [ENTRIES-1:0] match;
  logic [MASK_W-1:0]  ent_mask [ENTRIES];
  half_t              ent_lo0  [ENTRIES];
  half_t              ent_lo1  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              live_q;
    logic [MASK_W-1:0] mask_q;
    logic [VPN2_W-1:0] vpn2_q;
    logic [ASID_W-1:0] asid_q;
    logic              glob_q;
    half_t             lo0_q, lo1_q;
    logic              we;
    logic [VPN2_W-1:0] care;

    assign we = stg_vld_q && (stg_idx_q == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  live_q <= 1'b0;
      else if (we) live_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        mask_q <= stg_mask_q;
        vpn2_q <= stg_vpn2_q;
        asid_q <= stg_asid_q;
        glob_q <= stg_g_q;
        lo0_q  <= stg_lo0_q;
        lo1_q  <= stg_lo1_q;
      end
    end

    assign care = ~{{(VPN2_W-MASK_W){1'b0}}, mask_q};
    assign match[g] = live_q
                    && (((vpn2_q ^ lk_vpn2) & care) == '0)
                    && (glob_q || (asid_q == lk_asid));
    assign ent_mask[g] = mask_q;
    assign ent_lo0[g]  = lo0_q;
    assign ent_lo1[g]  = lo1_q;
  end

  // lowest-numbered matching row wins
  always_comb begin
    sel_hit  = 1'b0;
    sel_mask = '0;
    sel_even = '0;
    sel_odd  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_hit  = 1'b1;
        sel_mask = ent_mask[i];
        sel_even = ent_lo0[i];
        sel_odd  = ent_lo1[i];
      end
    end
  end

endmodule

// File: rtl/pair_tlb_xlate.sv
module pair_tlb_xlate
  import pair_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_store,
  input  logic              sel_hit,
  input  logic [MASK_W-1:0] sel_mask,
  input  half_t             sel_even,
  input  half_t             sel_odd,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_fault,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_cca,
  output logic              rsp_uncached
);

  logic [SPAN_W-1:0] span;
  logic [POS_W-1:0]  sel_pos;
  logic              odd;
  half_t             half;
  logic [PFN_W-1:0]  off_mask;
  logic [PFN_W-1:0]  frame;
  fault_e            fault_d;
  logic              valid_d, hit_d, unc_d;
  logic [VA_W-1:0]   pa_d;

  always_comb begin
    span     = mask_span(sel_mask);
    sel_pos  = POS_W'(PG_SHIFT) + POS_W'(span);
    odd      = lk_va[sel_pos];
    half     = odd ? sel_odd : sel_even;
    off_mask = (PFN_W'(1) << span) - PFN_W'(1);
    frame    = (half.pfn & ~off_mask) | (lk_va[VA_W-1:PG_SHIFT] & off_mask);
    pa_d     = {frame, lk_va[PG_SHIFT-1:0]};

    if (!sel_hit)                     fault_d = FLT_MISS;
    else if (!half.valid)             fault_d = FLT_INVALID;
    else if (lk_store && !half.dirty) fault_d = FLT_MODIFIED;
    else                              fault_d = FLT_NONE;

    hit_d   = (fault_d == FLT_NONE);
    unc_d   = (half.cca == CCA_UNCACHED);
    valid_d = lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_fault    <= FLT_NONE;
      rsp_pa       <= '0;
      rsp_cca      <= '0;
      rsp_uncached <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      if (lk_valid) begin
        rsp_hit      <= hit_d;
        rsp_fault    <= fault_d;
        rsp_pa       <= pa_d;
        rsp_cca      <= half.cca;
        rsp_uncached <= unc_d;
      end
    end
  end

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int ASID_W  = 8,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rsv_count,
  input  logic              wr_en,
  input  logic              wr_rand,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [2:0]        wr_cca0,
  input  logic              wr_dirty0,
  input  logic              wr_valid0,
  input  logic              wr_glob0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic [2:0]        wr_cca1,
  input  logic              wr_dirty1,
  input  logic              wr_valid1,
  input  logic              wr_glob1,
  output logic              busy,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_fault,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_cca,
  output logic              rsp_uncached
);

  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [IDX_W-1:0]  rep_idx;
  half_t             lo0, lo1;
  logic              sel_hit;
  logic [MASK_W-1:0] sel_mask;
  half_t             sel_even, sel_odd;

  assign lo0 = '{pfn: wr_pfn0, cca: wr_cca0, dirty: wr_dirty0, valid: wr_valid0};
  assign lo1 = '{pfn: wr_pfn1, cca: wr_cca1, dirty: wr_dirty1, valid: wr_valid1};

  pair_tlb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk       (clk),
    .rst_n     (rst_s),
    .rsv_count (rsv_count),
    .ptr       (rep_idx)
  );

  pair_tlb_store #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (wr_en),
    .wr_rand  (wr_rand),
    .wr_index (wr_index),
    .rep_idx  (rep_idx),
    .wr_mask  (wr_mask),
    .wr_vpn2  (wr_vpn2),
    .wr_asid  (wr_asid),
    .wr_lo0   (lo0),
    .wr_lo1   (lo1),
    .wr_g0    (wr_glob0),
    .wr_g1    (wr_glob1),
    .busy     (busy),
    .lk_vpn2  (lk_va[VA_W-1:PG_SHIFT+1]),
    .lk_asid  (lk_asid),
    .sel_hit  (sel_hit),
    .sel_mask (sel_mask),
    .sel_even (sel_even),
    .sel_odd  (sel_odd)
  );

  pair_tlb_xlate u_xlate (
    .clk          (clk),
    .rst_n        (rst_s),
    .lk_valid     (lk_valid),
    .lk_va        (lk_va),
    .lk_store     (lk_store),
    .sel_hit      (sel_hit),
    .sel_mask     (sel_mask),
    .sel_even     (sel_even),
    .sel_odd      (sel_odd),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_fault    (rsp_fault),
    .rsp_pa       (rsp_pa),
    .rsp_cca      (rsp_cca),
    .rsp_uncached (rsp_uncached)
  );

endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             busy,
  input logic             lk_valid,
  input logic [11:0]      lk_va_lo,
  input logic             lk_store,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [1:0]       rsp_fault,
  input logic [11:0]      rsp_pa_lo,
  input logic [IDX_W-1:0] rep_idx,
  input logic [IDX_W-1:0] rsv_count
);

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);

  // R2
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R10
  no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R8
  modified_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b11) |-> $past(lk_store));

  // R6
  offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_pa_lo == $past(lk_va_lo)));

  // R3
  repl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rep_idx >= $past(rsv_count)));

endmodule

bind pair_tlb pair_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .wr_en     (wr_en),
  .busy      (busy),
  .lk_valid  (lk_valid),
  .lk_va_lo  (lk_va[11:0]),
  .lk_store  (lk_store),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_pa_lo (rsp_pa[11:0]),
  .rep_idx   (rep_idx),
  .rsv_count (rsv_count)
);

// File: tb/sim_pair_tlb.sv
`timescale 1ns/1ps
module sim_pair_tlb;

  localparam int N = 16;

  logic        clk, rst_n;
  logic [3:0]  rsv_count;
  logic        wr_en, wr_rand;
  logic [3:0]  wr_index;
  logic [7:0]  wr_mask;
  logic [18:0] wr_vpn2;
  logic [7:0]  wr_asid;
  logic [19:0] wr_pfn0, wr_pfn1;
  logic [2:0]  wr_cca0, wr_cca1;
  logic        wr_dirty0, wr_valid0, wr_glob0;
  logic        wr_dirty1, wr_valid1, wr_glob1;
  logic        busy;
  logic        lk_valid, lk_store;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        rsp_valid, rsp_hit, rsp_uncached;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_cca;

  pair_tlb #(.ENTRIES(N), .ASID_W(8)) u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          mlive [N];
  logic [7:0]  mmask [N];
  logic [18:0] mvpn  [N];
  logic [7:0]  masid [N];
  bit          mglob [N];
  logic [19:0] mpfn  [N][2];
  logic [2:0]  mcca  [N][2];
  bit          mdirty[N][2];
  bit          mvalid[N][2];

  // replacement pointer per R3, with the two-edge reset release of R1
  logic [1:0] mrs;
  logic [3:0] mptr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs  <= 2'b00;
      mptr <= 4'd0;
    end else begin
      mrs <= {mrs[0], 1'b1};
      if (mrs[1]) begin
        if (mptr < rsv_count || mptr >= 4'(N - 1)) mptr <= rsv_count;
        else                                      mptr <= mptr + 4'd1;
      end
    end
  end

  function automatic void predict(input logic [31:0] va, input logic [7:0] asid, input bit st,
                                  output logic [1:0] f, output logic [31:0] pa, output logic [2:0] cca);
    int e = -1;
    int n;
    int s;
    for (int i = 0; i < N; i++) begin
      if (e < 0 && mlive[i]
          && (((mvpn[i] ^ va[31:13]) & ~{11'b0, mmask[i]}) == 19'd0)
          && (mglob[i] || masid[i] == asid))
        e = i;
    end
    pa = '0; cca = '0;
    if (e < 0) begin f = 2'b01; return; end
    n = $countones(mmask[e]);
    s = va[12 + n] ? 1 : 0;
    pa[11:0] = va[11:0];
    for (int k = 0; k < 20; k++) pa[12 + k] = (k < n) ? va[12 + k] : mpfn[e][s][k];
    cca = mcca[e][s];
    if (!mvalid[e][s])                 f = 2'b10;
    else if (st && !mdirty[e][s])      f = 2'b11;
    else                               f = 2'b00;
  endfunction

  // ---------------- driver tasks (entered and left at a falling edge) ----------------
  task automatic drive_wr(input bit rnd, input logic [3:0] idx, input logic [7:0] mask,
                          input logic [18:0] vpn, input logic [7:0] asid,
                          input logic [19:0] p0, input logic [2:0] c0, input bit d0, input bit v0, input bit g0,
                          input logic [19:0] p1, input logic [2:0] c1, input bit d1, input bit v1, input bit g1);
    wr_en = 1'b1; wr_rand = rnd; wr_index = idx; wr_mask = mask; wr_vpn2 = vpn; wr_asid = asid;
    wr_pfn0 = p0; wr_cca0 = c0; wr_dirty0 = d0; wr_valid0 = v0; wr_glob0 = g0;
    wr_pfn1 = p1; wr_cca1 = c1; wr_dirty1 = d1; wr_valid1 = v1; wr_glob1 = g1;
  endtask

  task automatic model_put(input int t, input logic [7:0] mask, input logic [18:0] vpn, input logic [7:0] asid,
                           input logic [19:0] p0, input logic [2:0] c0, input bit d0, input bit v0, input bit g0,
                           input logic [19:0] p1, input logic [2:0] c1, input bit d1, input bit v1, input bit g1);
    mlive[t] = 1; mmask[t] = mask; mvpn[t] = vpn; masid[t] = asid; mglob[t] = g0 & g1;
    mpfn[t][0] = p0; mcca[t][0] = c0; mdirty[t][0] = d0; mvalid[t][0] = v0;
    mpfn[t][1] = p1; mcca[t][1] = c1; mdirty[t][1] = d1; mvalid[t][1] = v1;
  endtask

  task automatic do_write(input bit rnd, input logic [3:0] idx, input logic [7:0] mask,
                          input logic [18:0] vpn, input logic [7:0] asid,
                          input logic [19:0] p0, input logic [2:0] c0, input bit d0, input bit v0, input bit g0,
                          input logic [19:0] p1, input logic [2:0] c1, input bit d1, input bit v1, input bit g1,
                          output int tgt);
    chk(busy === 1'b0, "R2 idle before write", 64'(busy), 64'd0);
    drive_wr(rnd, idx, mask, vpn, asid, p0, c0, d0, v0, g0, p1, c1, d1, v1, g1);
    tgt = rnd ? int'(mptr) : int'(idx);
    model_put(tgt, mask, vpn, asid, p0, c0, d0, v0, g0, p1, c1, d1, v1, g1);
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy === 1'b1, "R2 busy after take", 64'(busy), 64'd1);
    @(negedge clk);
    chk(busy === 1'b0, "R2 busy one cycle", 64'(busy), 64'd0);
  endtask

  task automatic do_look(input logic [31:0] va, input logic [7:0] asid, input bit st, input string req);
    logic [1:0]  ef;
    logic [31:0] epa;
    logic [2:0]  ecca;
    predict(va, asid, st, ef, epa, ecca);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid === 1'b1, {req, " R10 strobe"}, 64'(rsp_valid), 64'd1);
    chk(rsp_fault === ef, {req, " fault"}, 64'(rsp_fault), 64'(ef));
    chk(rsp_hit === (ef == 2'b00), {req, " R10 hit flag"}, 64'(rsp_hit), 64'(ef == 2'b00));
    if (ef == 2'b00) begin
      chk(rsp_pa === epa, {req, " R6 address"}, 64'(rsp_pa), 64'(epa));
      chk(rsp_cca === ecca, {req, " R9 code"}, 64'(rsp_cca), 64'(ecca));
      chk(rsp_uncached === (ecca == 3'b010), {req, " R9 uncached"}, 64'(rsp_uncached), 64'(ecca == 3'b010));
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, {req, " R10 single strobe"}, 64'(rsp_valid), 64'd0);
  endtask

  function automatic logic [7:0] pick_mask();
    case ($urandom % 5)
      0: return 8'h00;
      1: return 8'h03;
      2: return 8'h0F;
      3: return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int t;
    int t2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rsv_count = 4'd0;
    wr_en = 0; wr_rand = 0; wr_index = 0; wr_mask = 0; wr_vpn2 = 0; wr_asid = 0;
    wr_pfn0 = 0; wr_cca0 = 0; wr_dirty0 = 0; wr_valid0 = 0; wr_glob0 = 0;
    wr_pfn1 = 0; wr_cca1 = 0; wr_dirty1 = 0; wr_valid1 = 0; wr_glob1 = 0;
    lk_valid = 0; lk_va = 0; lk_asid = 0; lk_store = 0;
    for (int i = 0; i < N; i++) mlive[i] = 0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
    chk(rsp_valid === 1'b0, "R1 no response in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_look(32'h1234_5678, 8'd1, 1'b0, "R1 empty miss");
    do_look(32'hFFFF_F000, 8'd0, 1'b1, "R1 empty miss store");

    // 4 KB pair, non-global, row 3
    do_write(0, 4'd3, 8'h00, 19'h12345, 8'd5,
             20'hAAAAA, 3'd3, 1, 1, 0, 20'h55555, 3'b010, 0, 1, 0, t);
    do_look({19'h12345, 1'b0, 12'h9AB}, 8'd5, 1'b0, "R5 even load");
    do_look({19'h12345, 1'b1, 12'h044}, 8'd5, 1'b0, "R9 odd uncached load");
    do_look({19'h12345, 1'b1, 12'h044}, 8'd5, 1'b1, "R8 odd store clean");
    do_look({19'h12345, 1'b0, 12'h010}, 8'd5, 1'b1, "R8 even store dirty");
    do_look({19'h12345, 1'b0, 12'h010}, 8'd6, 1'b0, "R4 foreign id");

    // global AND
    do_write(0, 4'd4, 8'h00, 19'h00400, 8'd1,
             20'h11111, 3'd0, 1, 1, 1, 20'h22222, 3'd0, 1, 1, 0, t);
    do_look({19'h00400, 1'b0, 12'h000}, 8'd9, 1'b0, "R4 half global");
    do_write(0, 4'd5, 8'h00, 19'h00500, 8'd1,
             20'h33333, 3'd7, 1, 1, 1, 20'h44444, 3'd5, 1, 1, 1, t);
    do_look({19'h00500, 1'b1, 12'h123}, 8'd9, 1'b0, "R4 both global");

    // invalid half, precedence over modified
    do_write(0, 4'd6, 8'h00, 19'h00600, 8'd2,
             20'h66666, 3'd3, 0, 0, 0, 20'h77777, 3'd3, 1, 1, 0, t);
    do_look({19'h00600, 1'b0, 12'h000}, 8'd2, 1'b0, "R7 invalid load");
    do_look({19'h00600, 1'b0, 12'h000}, 8'd2, 1'b1, "R7 invalid store");

    // large pages
    do_write(0, 4'd7, 8'h0F, 19'h70000, 8'd3,
             20'hABCDE, 3'd1, 1, 1, 0, 20'hFEDCB, 3'd4, 1, 1, 0, t);
    do_look(32'hE001_6ABC, 8'd3, 1'b0, "R5 64K odd");
    do_look(32'hE000_E123, 8'd3, 1'b0, "R5 64K even");
    do_write(0, 4'd8, 8'hFF, 19'h20000, 8'd3,
             20'h12345, 3'd2, 1, 1, 0, 20'h6789A, 3'd6, 1, 1, 0, t);
    do_look(32'h401F_FFFF, 8'd3, 1'b0, "R6 1M odd");
    do_look(32'h400A_5555, 8'd3, 1'b0, "R6 1M even");

    // R2: request during busy is dropped
    drive_wr(0, 4'd9, 8'h00, 19'h09000, 8'd4, 20'h90000, 3'd3, 1, 1, 0, 20'h90001, 3'd3, 1, 1, 0);
    model_put(9, 8'h00, 19'h09000, 8'd4, 20'h90000, 3'd3, 1, 1, 0, 20'h90001, 3'd3, 1, 1, 0);
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy", 64'(busy), 64'd1);
    drive_wr(0, 4'd10, 8'h00, 19'h0A000, 8'd4, 20'hA0000, 3'd3, 1, 1, 0, 20'hA0001, 3'd3, 1, 1, 0);
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy === 1'b0, "R2 dropped request", 64'(busy), 64'd0);
    @(negedge clk);
    do_look({19'h0A000, 1'b0, 12'h000}, 8'd4, 1'b0, "R2 dropped entry absent");
    do_look({19'h09000, 1'b0, 12'h000}, 8'd4, 1'b0, "R2 taken entry present");

    // R11 overlapping tags
    do_write(0, 4'd11, 8'h00, 19'h0B000, 8'd0, 20'hB1111, 3'd3, 1, 1, 1, 20'hB1112, 3'd3, 1, 1, 1, t);
    do_write(0, 4'd12, 8'h00, 19'h0B000, 8'd0, 20'hC2222, 3'd3, 1, 1, 1, 20'hC2223, 3'd3, 1, 1, 1, t);
    do_look({19'h0B000, 1'b0, 12'h321}, 8'd7, 1'b0, "R11 lowest row");

    // R3 replacement writes
    rsv_count = 4'd13;
    repeat (3) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      repeat ($urandom % 4) @(negedge clk);
      do_write(1, 4'd0, 8'h00, 19'h0D000 + 19'(j), 8'd8,
               20'hD0000 + 20'(j), 3'd3, 1, 1, 0, 20'hD1000, 3'd3, 1, 1, 0, t);
      chk(t >= 13, "R3 pointer above reserved rows", 64'(t), 64'd13);
      do_look({19'h0D000 + 19'(j), 1'b0, 12'h000}, 8'd8, 1'b0, "R3 random row hit");
      do_write(0, 4'(t), 8'h00, 19'h0E000 + 19'(j), 8'd8,
               20'hE0000, 3'd3, 1, 1, 0, 20'hE1000, 3'd3, 1, 1, 0, t2);
      do_look({19'h0D000 + 19'(j), 1'b0, 12'h000}, 8'd8, 1'b0, "R3 row overwritten");
    end

    // random traffic
    rsv_count = 4'd2;
    for (int it = 0; it < 600; it++) begin
      if ($urandom % 4 == 0) begin
        do_write(($urandom % 4) == 0, 4'($urandom), pick_mask(), 19'($urandom), 8'($urandom % 4),
                 20'($urandom), 3'($urandom), 1'($urandom), ($urandom % 5) != 0, 1'($urandom),
                 20'($urandom), 3'($urandom), 1'($urandom), ($urandom % 5) != 0, 1'($urandom), t);
      end else begin
        int e;
        logic [31:0] va;
        logic [7:0]  as;
        e  = $urandom % N;
        va = $urandom;
        as = 8'($urandom % 4);
        if (mlive[e] && ($urandom % 4) != 0) begin
          va[31:13] = mvpn[e] ^ ({11'b0, mmask[e]} & 19'($urandom));
          if ($urandom % 2) as = masid[e];
        end
        do_look(va, as, 1'($urandom), "R5 R8 R9 random");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule